// File: doc/BRIEF.md
# UART Interrupt Mask and Status Unit

This unit gathers the interrupt sources of a UART into one raw status word, gates that word with a mask of per-source enables, and drives the interrupt lines. There are six sources: receive, transmit, overrun, break, parity error and framing error.

The receive and transmit sources are level conditions that come from the FIFO trigger logic, and their raw bits follow those levels. The four error sources arrive as one-cycle strobes from the character receiver. Each error strobe sets a sticky raw bit, and software clears that bit by writing a 1 to it through the clear register.

Every masked bit has its own output line. A dedicated error line covers the four receive-error sources, and a global line covers all six. A small register port gives access to the enable mask, the raw word, the masked word and the clear register.

Status bit positions, LSB first:

| Bit | Source |
|---|---|
| 0 | receive |
| 1 | transmit |
| 2 | overrun |
| 3 | break |
| 4 | parity error |
| 5 | framing error |

Register addresses:

| Address | Register | Access |
|---|---|---|
| 0 | enable mask | read/write |
| 1 | raw status | read-only |
| 2 | masked status | read-only |
| 3 | clear | write-only, reads 0 |

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset is asserted (`rst_ni` low), the enable mask is 0 and all error raw bits (bits 2..5) are 0. With rx and tx levels low, `irq_src_o`, `irq_err_o` and `irq_o` are all 0.
- R2: Raw bit 0 equals `rx_level_i` and raw bit 1 equals `tx_level_i`, in the same cycle and with no register in the path.
- R3: A strobe on `err_evt_i[k]` (k=0 overrun, 1 break, 2 parity, 3 framing) sets raw bit k+2 from the next clock edge. The bit stays set until it is cleared.
- R4: A write to address 3 clears, at the next edge, every error raw bit whose write-data bit (2..5) is 1. Error bits whose write-data bit is 0 are unchanged. Write-data bits 0 and 1 have no effect.
- R5: When a strobe and a clear hit the same error bit in the same cycle, the bit is set after the edge, because the strobe wins.
- R6: A write to address 0 loads the enable mask from `reg_wdata_i` at the next edge. A 1 enables the source. A read of address 0 returns the mask.
- R7: `masked_o` equals `raw_o` AND the mask, and `irq_src_o` equals `masked_o` bit for bit.
- R8: `irq_err_o` is the OR of masked bits 2..5. The rx and tx sources never drive it.
- R9: `irq_o` is the OR of all six masked bits.
- R10: A read of address 1 returns the raw word, a read of address 2 returns the masked word, and a read of address 3 returns 0. Reads are combinational.
- R11: Writes to addresses 1 and 2 change neither the mask nor the raw status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_level_i | input | 1 | Receive trigger-level condition |
| tx_level_i | input | 1 | Transmit trigger-level condition |
| err_evt_i | input | 4 | Error strobes: overrun, break, parity, framing |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 6 | Register write data |
| reg_rdata_o | output | 6 | Register read data |
| raw_o | output | 6 | Raw status word |
| masked_o | output | 6 | Masked status word |
| irq_src_o | output | 6 | Per-source interrupt lines |
| irq_err_o | output | 1 | Combined receive-error interrupt |
| irq_o | output | 1 | Global combined interrupt |

## Verification
The bench uses the default six-source build with its 2-bit address. At this size, every one of the 64 mask values can be crossed with every one of the 64 raw patterns, and each raw pattern is formed from two levels and four latched strobes. This sweep checks the per-line gating and both OR trees over their whole input space. It also checks that the error line stays quiet for any rx/tx combination. Directed sequences then cover partial clears, a strobe and a clear colliding on the same bit, and writes to the read-only addresses.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned NUM_ERR = 4;
  localparam int unsigned NUM_SRC = NUM_ERR + 2;
  localparam int unsigned ADDR_W  = 2;

  localparam int unsigned IDX_RX  = 0;
  localparam int unsigned IDX_TX  = 1;
  localparam int unsigned IDX_ERR = 2;

  typedef logic [NUM_SRC-1:0] src_vec_t;
  typedef logic [NUM_ERR-1:0] err_vec_t;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_MASK   = 2'd0,
    ADDR_RAW    = 2'd1,
    ADDR_MASKED = 2'd2,
    ADDR_CLR    = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/uart_irq_err_latch.sv
module uart_irq_err_latch #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    // set has priority over clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[k] <= 1'b0;
      else if (set_i[k]) q_o[k] <= 1'b1;
      else if (clr_i[k]) q_o[k] <= 1'b0;
    end

    assert_err_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> q_o[k]);
    assert_err_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] && !set_i[k]) |=> !q_o[k]);
    assert_err_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q_o[k] && !clr_i[k]) |=> q_o[k]);
    assert_err_no_spurious_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!q_o[k] && !set_i[k]) |=> !q_o[k]);
  end
endmodule

// File: rtl/uart_irq_mask_reg.sv
module uart_irq_mask_reg #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i;
  end

  assert_mask_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (q_o == $past(wdata_i)));
  assert_mask_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/uart_irq_combine.sv
module uart_irq_combine #(
  parameter int unsigned N_SRC   = 6,
  parameter int unsigned ERR_LSB = 2
) (
  input  logic [N_SRC-1:0] raw_i,
  input  logic [N_SRC-1:0] mask_i,
  output logic [N_SRC-1:0] masked_o,
  output logic             err_o,
  output logic             any_o
);
  localparam int unsigned N_ERR = N_SRC - ERR_LSB;

  always_comb masked_o = raw_i & mask_i;

  logic [N_ERR-1:0] err_terms;
  for (genvar k = 0; k < N_ERR; k++) begin : g_err
    assign err_terms[k] = masked_o[ERR_LSB+k];
  end

  assign err_o = |err_terms;
  assign any_o = |masked_o;
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rx_level_i,
  input  logic               tx_level_i,
  input  logic [NUM_ERR-1:0] err_evt_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [NUM_SRC-1:0] reg_wdata_i,
  output logic [NUM_SRC-1:0] reg_rdata_o,
  output logic [NUM_SRC-1:0] raw_o,
  output logic [NUM_SRC-1:0] masked_o,
  output logic [NUM_SRC-1:0] irq_src_o,
  output logic               irq_err_o,
  output logic               irq_o
);
  src_vec_t mask_q;
  err_vec_t err_q;
  err_vec_t err_clr;
  logic     mask_we;
  logic     clr_we;

  assign mask_we = reg_we_i && (reg_addr_i == ADDR_MASK);
  assign clr_we  = reg_we_i && (reg_addr_i == ADDR_CLR);
  assign err_clr = clr_we ? reg_wdata_i[IDX_ERR +: NUM_ERR] : '0;

  uart_irq_mask_reg #(.W(NUM_SRC)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mask_we),
    .wdata_i (reg_wdata_i),
    .q_o     (mask_q)
  );

  uart_irq_err_latch #(.N(NUM_ERR)) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (err_evt_i),
    .clr_i  (err_clr),
    .q_o    (err_q)
  );

  always_comb begin
    raw_o                     = '0;
    raw_o[IDX_RX]             = rx_level_i;
    raw_o[IDX_TX]             = tx_level_i;
    raw_o[IDX_ERR +: NUM_ERR] = err_q;
  end

  uart_irq_combine #(.N_SRC(NUM_SRC), .ERR_LSB(IDX_ERR)) u_comb (
    .raw_i    (raw_o),
    .mask_i   (mask_q),
    .masked_o (masked_o),
    .err_o    (irq_err_o),
    .any_o    (irq_o)
  );

  assign irq_src_o = masked_o;

  always_comb begin
    unique case (reg_addr_i)
      ADDR_MASK:   reg_rdata_o = mask_q;
      ADDR_RAW:    reg_rdata_o = raw_o;
      ADDR_MASKED: reg_rdata_o = masked_o;
      default:     reg_rdata_o = '0;
    endcase
  end

  assert_err_implies_any_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_err_o |-> irq_o);
  assert_masked_within_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_src_o & ~mask_q) == '0);
  assert_any_needs_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (raw_o != '0));
  assert_ro_write_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && (reg_addr_i == ADDR_RAW || reg_addr_i == ADDR_MASKED)) |=> $stable(mask_q));
  assert_err_line_err_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_err_o |-> (err_q != '0));
endmodule

// File: tb/uart_irq_ctrl_bench.sv
module uart_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_lvl = 1'b0, tx_lvl = 1'b0;
  logic [3:0] evt = '0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [5:0] wdata = '0;
  logic [5:0] rdata, raw, masked, src;
  logic       irq_err, irq;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  uart_irq_ctrl u_uart_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .rx_level_i(rx_lvl), .tx_level_i(tx_lvl),
    .err_evt_i(evt), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .raw_o(raw), .masked_o(masked), .irq_src_o(src),
    .irq_err_o(irq_err), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive just after an edge, so registered effects are visible after the next one
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [5:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0; wdata = '0;
  endtask

  task automatic strobe(input logic [3:0] e);
    evt = e;
    tick();
    evt = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [5:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [5:0] r;
    #2;
    // R1 reset state
    chk("R1 mask", {26'd0, u_mask_read()}, 32'd0);
    chk("R1 raw", {26'd0, raw}, 32'd0);
    chk("R1 lines", {25'd0, src, irq}, 32'd0);
    chk("R1 err", {31'd0, irq_err}, 32'd0);
    rst_n = 1'b1;
    tick();

    // exhaustive sweep: mask x raw pattern (R2, R3, R4, R6, R7, R8, R9, R10)
    for (int m = 0; m < 64; m++) begin
      wr(2'd0, 6'(m));
      rd(2'd0, r);
      chk("R6 mask readback", {26'd0, r}, m);
      for (int p = 0; p < 64; p++) begin
        logic [5:0] pv, exp_m;
        pv = 6'(p);
        wr(2'd3, 6'h3f);
        rx_lvl = pv[0]; tx_lvl = pv[1];
        strobe(pv[5:2]);
        exp_m = pv & 6'(m);
        chk("R2 R3 raw", {26'd0, raw}, pv);
        chk("R7 masked", {26'd0, masked}, exp_m);
        chk("R7 src lines", {26'd0, src}, exp_m);
        chk("R8 err line", {31'd0, irq_err}, {31'd0, |exp_m[5:2]});
        chk("R9 any line", {31'd0, irq}, {31'd0, |exp_m});
        rd(2'd1, r); chk("R10 raw read", {26'd0, r}, pv);
        rd(2'd2, r); chk("R10 masked read", {26'd0, r}, exp_m);
        rd(2'd3, r); chk("R10 clr read", {26'd0, r}, 0);
      end
    end
    rx_lvl = 1'b0; tx_lvl = 1'b0;

    // R4 partial clear, bits 0/1 of clear ignored
    wr(2'd0, 6'h3f);
    wr(2'd3, 6'h3f);
    strobe(4'hf);
    chk("R3 all set", {26'd0, raw}, 6'h3c);
    wr(2'd3, 6'b01_0111);
    chk("R4 partial clear", {26'd0, raw}, 6'b10_1000);
    rx_lvl = 1'b1; tx_lvl = 1'b1;
    wr(2'd3, 6'b00_0011);
    chk("R4 low bits no effect", {26'd0, raw}, 6'b10_1011);
    rx_lvl = 1'b0; tx_lvl = 1'b0;
    #1;
    chk("R2 levels drop", {26'd0, raw}, 6'b10_1000);

    // R5 set beats clear
    wr(2'd3, 6'h3f);
    evt = 4'b0101; we = 1'b1; addr = 2'd3; wdata = 6'h3f;
    tick();
    evt = '0; we = 1'b0;
    chk("R5 set wins", {26'd0, raw}, 6'b01_0100);

    // R11 writes to read-only addresses
    wr(2'd0, 6'b10_1010);
    wr(2'd1, 6'h00);
    wr(2'd2, 6'h15);
    rd(2'd0, r);
    chk("R11 mask kept", {26'd0, r}, 6'b10_1010);
    chk("R11 raw kept", {26'd0, raw}, 6'b01_0100);

    // R1 reset again clears mask and latches
    rst_n = 1'b0;
    #1;
    chk("R1 raw after reset", {26'd0, raw}, 0);
    rd(2'd0, r);
    chk("R1 mask after reset", {26'd0, r}, 0);
    chk("R1 irq after reset", {31'd0, irq}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // reads the mask through the register port at address 0
  function automatic logic [5:0] u_mask_read();
    return (addr == 2'd0) ? rdata : 6'h3f;
  endfunction
endmodule